// File: doc/BRIEF.md
# Data Watchpoint Range Matcher

This block keeps a small bank of hardware watchpoints. Each watchpoint is a pair of registers: an address word and a control word. The block turns each pair into a watched byte range. It then compares every data access presented to it against all enabled ranges at once. An access is described by its address, its size, a load/store flag and a flag for unprivileged accesses.

A range can be written in two ways:
- A power-of-two size field gives a block aligned to its own size.
- When the size field is zero, a byte-select field gives a contiguous run of bytes. The run starts at the select's lowest set bit, and its length is the number of consecutive ones from that bit.

A range hit only counts when the entry's filters also pass:
- the security-state filter;
- the privilege-level filter;
- an optional context link, which selects one bit of a linked-match vector driven by the breakpoint comparators.

The whole bank is gated by a monitor enable and a debug-permitted input. A legacy big-endian mode swizzles the address of narrow accesses before comparison.

Results are registered, one cycle after the access. A hit reports:
- the lowest-numbered matching entry;
- the access address as presented;
- whether the access was a store.

Configuration writes select an entry and either its address or its control word. All parameters keep the defaults: `NUM_WP` = 4 and `AW` = 32. `AW` must be at least 32.

Top module: `wp_range_matcher`

## Requirements
- R1: After synchronous reset every entry is disabled and `rsp_valid`, `rsp_hit`, `rsp_wnr` are 0; an access then gets a miss.
- R2: Writing an address word stores it with bits [1:0] forced to zero.
- R3: Control bit 0 enables the entry. Control bits [4:3] select the access kinds: bit 3 watches loads and bit 4 watches stores, so 0 watches nothing and 3 watches both. A disabled entry never hits.
- R4: Control bits [28:24] form the size field. Values 1 and 2 watch nothing. A value k ≥ 3 watches 2^k bytes from the stored address rounded down to a multiple of 2^k.
- R5: With a size field of 0, the byte-select field in control bits [12:5] is used.
  - When bit 2 of the stored address is 1, only select bits [3:0] count.
  - An effective select of 0 watches nothing.
  - Otherwise the range starts at the stored address plus the index of the lowest set select bit, and its length is the count of consecutive ones from that bit.
- R6: An access of 2^`acc_size` bytes hits when any of its bytes lies inside the watched range.
- R7: Privilege filter.
  - At level 1 the entry requires control bit 1.
  - At level 0 it requires control bit 2.
  - At levels 2 and 3 it requires control bit 13.
  - An access with `acc_unpriv` set is filtered as level 0, whatever `cur_el` is.
- R8: Security filter in control bits [15:14]. A value of 0 accepts both states, 2 accepts only the secure state, and 1 or 3 accept only the non-secure state.
- R9: When control bit 20 is set, a hit also requires `link_match[lbn]`, where `lbn` is control bits [19:16].
- R10: No entry hits unless both `mon_en` and `dbg_en` are 1.
- R11: With `be32` set, the comparison address is swizzled before matching: `acc_addr` XOR 3 for 1-byte accesses and `acc_addr` XOR 2 for 2-byte accesses. Wider accesses are unchanged.
- R12: Each access gives `rsp_valid` exactly one cycle later. On a hit:
  - `rsp_idx` is the lowest matching entry;
  - `rsp_addr` is the unswizzled `acc_addr`;
  - `rsp_wnr` equals `acc_write`.

  On a miss, `rsp_addr` and `rsp_wnr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_is_ctrl | input | 1 | 1 writes the control word, 0 writes the address word |
| cfg_idx | input | IW | Entry selected by the write |
| cfg_wdata | input | AW | Write data |
| mon_en | input | 1 | Monitor debug enable |
| dbg_en | input | 1 | Debug exceptions currently permitted |
| cur_el | input | 2 | Current privilege level 0..3 |
| sec_state | input | 1 | 1 when executing in the secure state |
| be32 | input | 1 | Legacy big-endian word-invariant mode |
| link_match | input | 16 | Context comparator match per link number |
| acc_valid | input | 1 | Access request valid |
| acc_addr | input | AW | Access byte address |
| acc_size | input | 2 | Access size code, 2^code bytes |
| acc_write | input | 1 | 1 for a store, 0 for a load |
| acc_unpriv | input | 1 | Access performed as unprivileged |
| rsp_valid | output | 1 | Result of the previous cycle's access |
| rsp_hit | output | 1 | A watchpoint matched |
| rsp_idx | output | IW | Lowest matching entry |
| rsp_addr | output | AW | Faulting data address |
| rsp_wnr | output | 1 | Hit was caused by a store |

## Verification
The checker watches the response timing on every cycle: one result per access, one cycle later. It also checks that no hit appears while the monitor or debug gate is closed, and that a hit carries the request address and store flag, with zeroed reporting fields on a miss. Whether a given range is right can only be shown by the bench's scenarios. That covers size-field and byte-select decoding, the bit-2 truncation, the low-bit clearing, byte overlap of wide accesses, the swizzle, the privilege, security and link filters, and lowest-entry priority.

// File: rtl/wpm_pkg.sv
package wpm_pkg;
  localparam int CTRL_W = 32;
  localparam int LINKS  = 16;

  typedef struct packed {
    logic [4:0] mask;
    logic       lnk;
    logic [3:0] lbn;
    logic [1:0] ssc;
    logic       hmc;
    logic [7:0] bas;
    logic [1:0] lsc;
    logic [1:0] pac;
    logic       en;
  } wp_ctrl_t;

  function automatic wp_ctrl_t unpack_ctrl(input logic [CTRL_W-1:0] w);
    wp_ctrl_t c;
    c.en   = w[0];
    c.pac  = w[2:1];
    c.lsc  = w[4:3];
    c.bas  = w[12:5];
    c.hmc  = w[13];
    c.ssc  = w[15:14];
    c.lbn  = w[19:16];
    c.lnk  = w[20];
    c.mask = w[28:24];
    return c;
  endfunction
endpackage

// File: rtl/wpm_range.sv
// Range derivation and overlap test for one watchpoint entry.
module wpm_range #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] val,
  input  logic          en,
  input  logic [1:0]    lsc,
  input  logic [7:0]    bas,
  input  logic [4:0]    mask,
  input  logic [AW-1:0] cmp_addr,
  input  logic [3:0]    cmp_len,
  input  logic          is_write,
  output logic          match
);
  localparam int EW = AW + 2;

  logic [7:0]    bas_eff;
  logic [2:0]    tz;
  logic [3:0]    run;
  logic          seen, stop;
  logic [EW-1:0] base_e, len_e, a_lo, a_hi;
  logic          span_ok, kind_ok, overlap;

  always_comb begin
    bas_eff = val[2] ? {4'b0000, bas[3:0]} : bas;
    tz   = 3'd0;
    seen = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (!seen && bas_eff[i]) begin
        tz   = 3'(i);
        seen = 1'b1;
      end
    end
    run  = 4'd0;
    stop = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (i >= int'(tz) && !stop) begin
        if (bas_eff[i]) run = run + 4'd1;
        else            stop = 1'b1;
      end
    end
  end

  always_comb begin
    if (mask >= 5'd3) begin
      len_e   = EW'(1) << mask;
      base_e  = {2'b00, val} & ~(len_e - EW'(1));
      span_ok = 1'b1;
    end else if (mask == 5'd0) begin
      len_e   = EW'(run);
      base_e  = {2'b00, val} + EW'(tz);
      span_ok = |bas_eff;
    end else begin
      len_e   = '0;
      base_e  = '0;
      span_ok = 1'b0;
    end
  end

  assign a_lo    = {2'b00, cmp_addr};
  assign a_hi    = a_lo + EW'(cmp_len);
  assign overlap = span_ok && (a_lo < base_e + len_e) && (base_e < a_hi);
  assign kind_ok = is_write ? lsc[1] : lsc[0];
  assign match   = en && kind_ok && overlap;
endmodule

// File: rtl/wpm_filter.sv
// Security, privilege and context-link qualification for one entry.
module wpm_filter #(
  parameter int LINKS = 16
) (
  input  logic [1:0]       pac,
  input  logic             hmc,
  input  logic [1:0]       ssc,
  input  logic [3:0]       lbn,
  input  logic             lnk,
  input  logic             secure,
  input  logic [1:0]       level,
  input  logic [LINKS-1:0] link_match,
  output logic             pass
);
  logic sec_ok, lvl_ok, lnk_ok;

  always_comb begin
    unique case (ssc)
      2'd0:    sec_ok = 1'b1;
      2'd2:    sec_ok = secure;
      default: sec_ok = !secure;
    endcase
    unique case (level)
      2'd0:    lvl_ok = pac[1];
      2'd1:    lvl_ok = pac[0];
      default: lvl_ok = hmc;
    endcase
  end

  assign lnk_ok = !lnk || link_match[lbn];
  assign pass   = sec_ok && lvl_ok && lnk_ok;
endmodule

// File: rtl/wpm_prio.sv
// Lowest-index-wins selection across entries.
module wpm_prio #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/wp_range_matcher.sv
module wp_range_matcher
  import wpm_pkg::*;
#(
  parameter int NUM_WP = 4,
  parameter int AW     = 32,
  localparam int IW    = (NUM_WP > 1) ? $clog2(NUM_WP) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic          cfg_is_ctrl,
  input  logic [IW-1:0] cfg_idx,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          mon_en,
  input  logic          dbg_en,
  input  logic [1:0]    cur_el,
  input  logic          sec_state,
  input  logic          be32,
  input  logic [15:0]   link_match,
  input  logic          acc_valid,
  input  logic [AW-1:0] acc_addr,
  input  logic [1:0]    acc_size,
  input  logic          acc_write,
  input  logic          acc_unpriv,
  output logic          rsp_valid,
  output logic          rsp_hit,
  output logic [IW-1:0] rsp_idx,
  output logic [AW-1:0] rsp_addr,
  output logic          rsp_wnr
);
  logic [AW-1:0] val_q  [NUM_WP];
  wp_ctrl_t      ctrl_q [NUM_WP];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_WP; i++) begin
        val_q[i]  <= '0;
        ctrl_q[i] <= '0;
      end
    end else if (cfg_we && int'(cfg_idx) < NUM_WP) begin
      if (cfg_is_ctrl) ctrl_q[cfg_idx] <= unpack_ctrl(cfg_wdata[CTRL_W-1:0]);
      else             val_q[cfg_idx]  <= cfg_wdata & ~AW'(3);
    end
  end

  logic [AW-1:0] cmp_addr;
  logic [3:0]    cmp_len;
  logic [1:0]    eff_level;
  logic          gate;

  always_comb begin
    cmp_addr = acc_addr;
    if (be32 && acc_size == 2'd0)      cmp_addr = acc_addr ^ AW'(3);
    else if (be32 && acc_size == 2'd1) cmp_addr = acc_addr ^ AW'(2);
  end
  assign cmp_len   = 4'd1 << acc_size;
  assign eff_level = acc_unpriv ? 2'd0 : cur_el;
  assign gate      = mon_en && dbg_en;

  logic [NUM_WP-1:0] hit_vec;

  for (genvar g = 0; g < NUM_WP; g++) begin : g_ent
    logic rng_hit, flt_ok;
    wpm_range #(.AW(AW)) u_rng (
      .val(val_q[g]), .en(ctrl_q[g].en), .lsc(ctrl_q[g].lsc),
      .bas(ctrl_q[g].bas), .mask(ctrl_q[g].mask),
      .cmp_addr(cmp_addr), .cmp_len(cmp_len), .is_write(acc_write),
      .match(rng_hit)
    );
    wpm_filter #(.LINKS(LINKS)) u_flt (
      .pac(ctrl_q[g].pac), .hmc(ctrl_q[g].hmc), .ssc(ctrl_q[g].ssc),
      .lbn(ctrl_q[g].lbn), .lnk(ctrl_q[g].lnk), .secure(sec_state),
      .level(eff_level), .link_match(link_match), .pass(flt_ok)
    );
    assign hit_vec[g] = gate && rng_hit && flt_ok;
  end

  logic          any_hit;
  logic [IW-1:0] win_idx;

  wpm_prio #(.N(NUM_WP), .IW(IW)) u_prio (
    .req(hit_vec), .any(any_hit), .idx(win_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_idx   <= '0;
      rsp_addr  <= '0;
      rsp_wnr   <= 1'b0;
    end else begin
      rsp_valid <= acc_valid;
      rsp_hit   <= acc_valid && any_hit;
      rsp_idx   <= (acc_valid && any_hit) ? win_idx : '0;
      rsp_addr  <= (acc_valid && any_hit) ? acc_addr : '0;
      rsp_wnr   <= acc_valid && any_hit && acc_write;
    end
  end
endmodule

// File: rtl/wpm_chk.sv
module wpm_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          mon_en,
  input logic          dbg_en,
  input logic          acc_valid,
  input logic [AW-1:0] acc_addr,
  input logic          acc_write,
  input logic          rsp_valid,
  input logic          rsp_hit,
  input logic [AW-1:0] rsp_addr,
  input logic          rsp_wnr
);
  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> rsp_valid); // R12
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> !rsp_valid); // R12
  AST_HIT_IMPLIES_VALID: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> rsp_valid); // R12
  AST_GATE_CLOSED: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !(mon_en && dbg_en)) |=> !rsp_hit); // R10
  AST_HIT_ADDR: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> (!rsp_hit || rsp_addr == $past(acc_addr))); // R12
  AST_LOAD_NO_WNR: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_write) |=> !rsp_wnr); // R12
  AST_MISS_QUIET: assert property (@(posedge clk) disable iff (rst)
    !rsp_hit |-> (rsp_addr == '0 && !rsp_wnr)); // R12
endmodule

bind wp_range_matcher wpm_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .mon_en(mon_en), .dbg_en(dbg_en),
  .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_write(acc_write),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_addr(rsp_addr),
  .rsp_wnr(rsp_wnr)
);

// File: tb/wp_range_matcher_tb.sv
module wp_range_matcher_tb;
  localparam int NUM_WP = 4;
  localparam int AW     = 32;
  localparam int IW     = 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst, cfg_we, cfg_is_ctrl;
  logic [IW-1:0] cfg_idx;
  logic [AW-1:0] cfg_wdata;
  logic          mon_en, dbg_en, sec_state, be32;
  logic [1:0]    cur_el;
  logic [15:0]   link_match;
  logic          acc_valid, acc_write, acc_unpriv;
  logic [AW-1:0] acc_addr;
  logic [1:0]    acc_size;
  logic          rsp_valid, rsp_hit, rsp_wnr;
  logic [IW-1:0] rsp_idx;
  logic [AW-1:0] rsp_addr;

  wp_range_matcher #(.NUM_WP(NUM_WP), .AW(AW)) u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_is_ctrl(cfg_is_ctrl),
    .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .mon_en(mon_en),
    .dbg_en(dbg_en), .cur_el(cur_el), .sec_state(sec_state), .be32(be32),
    .link_match(link_match), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_size(acc_size), .acc_write(acc_write), .acc_unpriv(acc_unpriv),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_idx(rsp_idx),
    .rsp_addr(rsp_addr), .rsp_wnr(rsp_wnr)
  );

  typedef struct {
    logic          hit;
    logic [IW-1:0] idx;
    logic [AW-1:0] addr;
    logic          wnr;
    string         tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_tests = 0;
  int   n_fail  = 0;
  bit   done    = 0;

  function automatic logic [31:0] mk(input logic en, input logic [1:0] pac,
      input logic [1:0] lsc, input logic [7:0] bas, input logic hmc,
      input logic [1:0] ssc, input logic [3:0] lbn, input logic lnk,
      input logic [4:0] mask);
    return {3'b000, mask, 3'b000, lnk, lbn, ssc, hmc, bas, lsc, pac, en};
  endfunction

  // plain entry: enabled, levels 0 and 1, both kinds
  function automatic logic [31:0] plain(input logic [7:0] bas, input logic [4:0] mask);
    return mk(1'b1, 2'b11, 2'b11, bas, 1'b0, 2'd0, 4'd0, 1'b0, mask);
  endfunction

  task automatic cfg(input int idx, input bit is_ctrl, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_is_ctrl = is_ctrl; cfg_idx = IW'(idx); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic clear_all();
    for (int i = 0; i < NUM_WP; i++) cfg(i, 1'b1, 32'd0);
  endtask

  task automatic acc(input logic [31:0] a, input logic [1:0] sz, input bit wr,
      input bit eh, input int eidx, input string tag);
    exp_t e;
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_size = sz; acc_write = wr;
    e.hit = eh; e.idx = eh ? IW'(eidx) : '0; e.addr = eh ? a : '0;
    e.wnr = eh && wr; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      exp_t e;
      n_tests++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R12: response with no request (hit=%0b) expected none", rsp_hit);
      end else begin
        e = exp_q.pop_front();
        if (rsp_hit !== e.hit || rsp_wnr !== e.wnr || rsp_addr !== e.addr ||
            (e.hit && rsp_idx !== e.idx)) begin
          n_fail++;
          $display("FAIL %s: got hit=%0b idx=%0d addr=%h wnr=%0b expected hit=%0b idx=%0d addr=%h wnr=%0b",
                   e.tag, rsp_hit, rsp_idx, rsp_addr, rsp_wnr,
                   e.hit, e.idx, e.addr, e.wnr);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; cfg_we = 1'b0; cfg_is_ctrl = 1'b0; cfg_idx = '0; cfg_wdata = '0;
    mon_en = 1'b1; dbg_en = 1'b1; cur_el = 2'd1; sec_state = 1'b0; be32 = 1'b0;
    link_match = '0; acc_valid = 1'b0; acc_addr = '0; acc_size = '0;
    acc_write = 1'b0; acc_unpriv = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_tests++;
    if (rsp_valid !== 1'b0 || rsp_hit !== 1'b0 || rsp_wnr !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: valid=%0b hit=%0b wnr=%0b expected 0 0 0", rsp_valid, rsp_hit, rsp_wnr);
    end
    rst = 1'b0;
    acc(32'h0, 2'd3, 1'b0, 1'b0, 0, "R1 no entry armed");

    // R2: low bits of value cleared
    cfg(0, 1'b0, 32'h1003);
    cfg(0, 1'b1, plain(8'h01, 5'd0));
    acc(32'h1003, 2'd0, 1'b0, 1'b0, 0, "R2 byte 3 not watched");
    acc(32'h1000, 2'd0, 1'b0, 1'b1, 0, "R2 byte 0 watched");

    // R3: kinds and enable
    cfg(0, 1'b1, mk(1'b1, 2'b11, 2'b01, 8'h01, 1'b0, 2'd0, 4'd0, 1'b0, 5'd0));
    acc(32'h1000, 2'd0, 1'b1, 1'b0, 0, "R3 store ignored by load-only");
    acc(32'h1000, 2'd0, 1'b0, 1'b1, 0, "R3 load hits");
    cfg(0, 1'b1, mk(1'b1, 2'b11, 2'b10, 8'h01, 1'b0, 2'd0, 4'd0, 1'b0, 5'd0));
    acc(32'h1000, 2'd0, 1'b1, 1'b1, 0, "R3 store hits store-only");
    acc(32'h1000, 2'd0, 1'b0, 1'b0, 0, "R3 load ignored by store-only");
    cfg(0, 1'b1, mk(1'b1, 2'b11, 2'b00, 8'h01, 1'b0, 2'd0, 4'd0, 1'b0, 5'd0));
    acc(32'h1000, 2'd0, 1'b1, 1'b0, 0, "R3 kind 0 watches nothing");
    cfg(0, 1'b1, mk(1'b0, 2'b11, 2'b11, 8'h01, 1'b0, 2'd0, 4'd0, 1'b0, 5'd0));
    acc(32'h1000, 2'd0, 1'b0, 1'b0, 0, "R3 disabled");

    // R4: mask mode
    cfg(0, 1'b0, 32'h2000);
    cfg(0, 1'b1, plain(8'hFF, 5'd2));
    acc(32'h2000, 2'd0, 1'b0, 1'b0, 0, "R4 mask 2 reserved");
    cfg(0, 1'b1, plain(8'hFF, 5'd1));
    acc(32'h2000, 2'd0, 1'b0, 1'b0, 0, "R4 mask 1 reserved");
    cfg(0, 1'b0, 32'h2018);
    cfg(0, 1'b1, plain(8'h00, 5'd4));
    acc(32'h2010, 2'd0, 1'b0, 1'b1, 0, "R4 aligned base");
    acc(32'h201F, 2'd0, 1'b0, 1'b1, 0, "R4 last byte");
    acc(32'h2020, 2'd0, 1'b0, 1'b0, 0, "R4 past end");
    acc(32'h200F, 2'd0, 1'b0, 1'b0, 0, "R4 before base");

    // R5: byte select
    cfg(0, 1'b0, 32'h3004);
    cfg(0, 1'b1, plain(8'hF0, 5'd0));
    acc(32'h3004, 2'd3, 1'b0, 1'b0, 0, "R5 upper select dropped");
    acc(32'h3008, 2'd0, 1'b0, 1'b0, 0, "R5 upper select dropped b");
    cfg(0, 1'b1, plain(8'h3C, 5'd0));
    acc(32'h3006, 2'd0, 1'b0, 1'b1, 0, "R5 truncated select start");
    acc(32'h3008, 2'd0, 1'b0, 1'b0, 0, "R5 truncated select end");
    cfg(0, 1'b0, 32'h3000);
    cfg(0, 1'b1, plain(8'h0C, 5'd0));
    acc(32'h3001, 2'd0, 1'b0, 1'b0, 0, "R5 below run");
    acc(32'h3002, 2'd0, 1'b0, 1'b1, 0, "R5 run start");
    acc(32'h3003, 2'd0, 1'b0, 1'b1, 0, "R5 run end");
    acc(32'h3004, 2'd0, 1'b0, 1'b0, 0, "R5 past run");
    cfg(0, 1'b1, plain(8'h00, 5'd0));
    acc(32'h3000, 2'd3, 1'b0, 1'b0, 0, "R5 zero select");
    cfg(0, 1'b1, plain(8'h6D, 5'd0));
    acc(32'h3000, 2'd0, 1'b0, 1'b1, 0, "R5 first run only");
    acc(32'h3002, 2'd0, 1'b0, 1'b0, 0, "R5 gap stops run");

    // R6: overlap of wide accesses
    cfg(0, 1'b1, plain(8'h0C, 5'd0));
    acc(32'h3000, 2'd2, 1'b0, 1'b1, 0, "R6 word covers run");
    acc(32'h2FF8, 2'd3, 1'b0, 1'b0, 0, "R6 dword below");
    acc(32'h3004, 2'd2, 1'b0, 1'b0, 0, "R6 word above");
    acc(32'h3003, 2'd1, 1'b0, 1'b1, 0, "R6 half straddling");

    // R7: privilege filter
    cfg(0, 1'b1, mk(1'b1, 2'b01, 2'b11, 8'h0C, 1'b0, 2'd0, 4'd0, 1'b0, 5'd0));
    cur_el = 2'd1;
    acc(32'h3002, 2'd0, 1'b0, 1'b1, 0, "R7 level1 allowed");
    acc_unpriv = 1'b1;
    acc(32'h3002, 2'd0, 1'b0, 1'b0, 0, "R7 unpriv acts as level0");
    acc_unpriv = 1'b0; cur_el = 2'd0;
    acc(32'h3002, 2'd0, 1'b0, 1'b0, 0, "R7 level0 blocked");
    cur_el = 2'd2;
    acc(32'h3002, 2'd0, 1'b0, 1'b0, 0, "R7 level2 blocked");
    cfg(0, 1'b1, mk(1'b1, 2'b10, 2'b11, 8'h0C, 1'b1, 2'd0, 4'd0, 1'b0, 5'd0));
    acc_unpriv = 1'b1;
    acc(32'h3002, 2'd0, 1'b0, 1'b1, 0, "R7 unpriv at level2 passes level0");
    acc_unpriv = 1'b0; cur_el = 2'd3;
    acc(32'h3002, 2'd0, 1'b0, 1'b1, 0, "R7 level3 via higher-mode bit");
    cur_el = 2'd1;
    acc(32'h3002, 2'd0, 1'b0, 1'b0, 0, "R7 level1 bit clear");

    // R8: security filter
    cfg(0, 1'b1, mk(1'b1, 2'b11, 2'b11, 8'h0C, 1'b0, 2'd2, 4'd0, 1'b0, 5'd0));
    sec_state = 1'b0;
    acc(32'h3002, 2'd0, 1'b0, 1'b0, 0, "R8 secure-only, nonsecure");
    sec_state = 1'b1;
    acc(32'h3002, 2'd0, 1'b0, 1'b1, 0, "R8 secure-only, secure");
    cfg(0, 1'b1, mk(1'b1, 2'b11, 2'b11, 8'h0C, 1'b0, 2'd3, 4'd0, 1'b0, 5'd0));
    acc(32'h3002, 2'd0, 1'b0, 1'b0, 0, "R8 nonsecure-only, secure");
    sec_state = 1'b0;
    acc(32'h3002, 2'd0, 1'b0, 1'b1, 0, "R8 nonsecure-only, nonsecure");

    // R9: link
    cfg(0, 1'b1, mk(1'b1, 2'b11, 2'b11, 8'h0C, 1'b0, 2'd0, 4'd5, 1'b1, 5'd0));
    link_match = 16'h0000;
    acc(32'h3002, 2'd0, 1'b0, 1'b0, 0, "R9 no link");
    link_match = 16'hFFDF;
    acc(32'h3002, 2'd0, 1'b0, 1'b0, 0, "R9 other links");
    link_match = 16'h0020;
    acc(32'h3002, 2'd0, 1'b0, 1'b1, 0, "R9 linked");
    link_match = 16'h0000;

    // R10: global gate
    cfg(0, 1'b1, plain(8'h0C, 5'd0));
    mon_en = 1'b0;
    acc(32'h3002, 2'd0, 1'b0, 1'b0, 0, "R10 monitor off");
    mon_en = 1'b1; dbg_en = 1'b0;
    acc(32'h3002, 2'd0, 1'b0, 1'b0, 0, "R10 debug off");
    dbg_en = 1'b1;

    // R11: big-endian swizzle
    cfg(0, 1'b0, 32'h4000);
    cfg(0, 1'b1, plain(8'h08, 5'd0));
    be32 = 1'b1;
    acc(32'h4000, 2'd0, 1'b0, 1'b1, 0, "R11 byte xor 3");
    acc(32'h4003, 2'd0, 1'b0, 1'b0, 0, "R11 byte xor 3 miss");
    acc(32'h4000, 2'd1, 1'b1, 1'b1, 0, "R11 half xor 2");
    acc(32'h4000, 2'd2, 1'b0, 1'b1, 0, "R11 word unchanged");
    be32 = 1'b0;
    acc(32'h4000, 2'd0, 1'b0, 1'b0, 0, "R11 swizzle off");

    // R12: priority and write flag
    clear_all();
    cfg(1, 1'b0, 32'h5000); cfg(1, 1'b1, plain(8'h00, 5'd3));
    cfg(2, 1'b0, 32'h5000); cfg(2, 1'b1, plain(8'h01, 5'd0));
    cfg(3, 1'b0, 32'h5004); cfg(3, 1'b1, plain(8'h0F, 5'd0));
    acc(32'h5000, 2'd0, 1'b1, 1'b1, 1, "R12 lowest entry wins");
    acc(32'h5004, 2'd2, 1'b1, 1'b1, 1, "R12 entries 1 and 3");
    acc(32'h5008, 2'd0, 1'b1, 1'b0, 0, "R12 miss quiet");
    cfg(1, 1'b1, 32'd0);
    acc(32'h5000, 2'd0, 1'b0, 1'b1, 2, "R12 next lowest, load");
    acc(32'h5006, 2'd0, 1'b1, 1'b1, 3, "R12 only entry 3");

    repeat (3) @(negedge clk);
    n_tests++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R12: %0d responses missing, expected 0", exp_q.size());
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule